// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller with Next-Block Prefetch

This block keeps only the bookkeeping side of a single-level, write-through cache. It holds no data. Each access brings a 48-bit byte address and a read/write flag. The block looks the address up in a set-associative tag store, answers hit or miss, allocates on a miss, and keeps least-recently-used order per set. It also maintains four running totals: block reads from memory, block writes to memory, hits and misses. The set count, the way count and the block size are power-of-two parameters. One set gives a fully associative cache. One way gives a direct-mapped cache.

A static enable turns on a next-block prefetcher. After a demand miss, the controller spends one extra internal cycle on the block that follows the missed one. If that block is absent, it is fetched and installed as most recently used. If it is already present, nothing happens: no memory read and no change to the replacement order. During that extra cycle the request channel is stalled, so accesses complete strictly in order. The totals can be compared directly against a software model of the same cache.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset every line is invalid, all four counters read zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Bits [log2(BLOCK_BYTES)-1:0] of the address are the byte offset and the next log2(SETS) bits select the set. All remaining upper bits of the 48-bit address form the tag.
- R3: One clock after an access is accepted, `rsp_valid` is 1 for one cycle. On a hit, `rsp_hit` is 1, the hit counter grows by one, and the hit way becomes most recently used.
- R4: On a miss, `rsp_hit` is 0 and the miss counter and the memory-read counter each grow by one. The block is installed into the lowest-numbered invalid way of its set, or else into the least recently used way, and becomes most recently used.
- R5: Replacement order depends only on recency. Any number of earlier hits on a way do not protect it once it is the least recently touched way of its set.
- R6: Every write access, hit or miss, adds one to the memory-write counter. A write miss also allocates the block and adds one memory read.
- R7: With `pf_en` at 1, only a demand miss triggers a prefetch. The prefetch targets the block whose block address is the missed block address plus one.
- R8: A prefetch of an absent block adds one memory read and installs the block as most recently used in its set. It does not change the hit or miss counters.
- R9: A prefetch of a block that is already present adds no memory read and leaves the replacement order of that set unchanged.
- R10: After a demand miss with `pf_en` at 1, `req_ready` is 0 for exactly one cycle. Otherwise `req_ready` stays 1.
- R11: With `pf_en` at 0, no prefetch takes place: the read counter grows only on demand misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_en | input | 1 | Static enable for next-block prefetch |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can accept an access |
| req_addr | input | 48 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Result of the previous accepted access |
| rsp_hit | output | 1 | 1 = that access hit |
| cnt_mem_rd | output | CNT_W | Blocks read from memory |
| cnt_mem_wr | output | CNT_W | Blocks written to memory |
| cnt_hit | output | CNT_W | Demand hits |
| cnt_miss | output | CNT_W | Demand misses |

## Verification
The hardest case to reach is a prefetch that finds its target block already present while that block is the least recently used way of its set. The only proof that the replacement order was left alone is which block a later miss in that set evicts. The stimulus first fills two sets through misses and prefetches. It then misses on the block just below a resident LRU block, so that the prefetch hits it. A further miss in the same set must evict that block and spare the other one. A follow-up hit on the spared block and a miss on the evicted block confirm the result at the ports.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PREF = 1'b1
  } ctl_state_t;
endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
  parameter int WAYS   = 2,
  parameter int TAG_W  = 45,
  parameter int RANK_W = 1,
  parameter int WAY_W  = 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
  input  logic [WAYS-1:0]             set_valid,
  input  logic [WAYS-1:0][RANK_W-1:0] set_ranks,
  input  logic [TAG_W-1:0]            look_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic [WAY_W-1:0]            victim_way
);
  logic [WAYS-1:0] match;
  logic [WAYS-1:0] is_oldest;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w]     = set_valid[w] && (set_tags[w] == look_tag);
    assign is_oldest[w] = (set_ranks[w] == RANK_W'(WAYS - 1));
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !set_valid[w]) begin
        victim_way = WAY_W'(w);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (is_oldest[w]) victim_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_rank_update.sv
module cache_rank_update #(
  parameter int WAYS   = 2,
  parameter int RANK_W = 1,
  parameter int WAY_W  = 1
) (
  input  logic [WAYS-1:0][RANK_W-1:0] cur_ranks,
  input  logic [WAY_W-1:0]            touch_way,
  output logic [WAYS-1:0][RANK_W-1:0] new_ranks
);
  logic [RANK_W-1:0] touched_rank;
  assign touched_rank = cur_ranks[touch_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_rank
    always_comb begin
      if (WAY_W'(w) == touch_way)
        new_ranks[w] = '0;
      else if (cur_ranks[w] < touched_rank)
        new_ranks[w] = cur_ranks[w] + 1'b1;
      else
        new_ranks[w] = cur_ranks[w];
    end
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int SETS        = 2,
  parameter int WAYS        = 2,
  parameter int BLOCK_BYTES = 4,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [47:0]       req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  cnt_mem_rd,
  output logic [CNT_W-1:0]  cnt_mem_wr,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_B  = $clog2(SETS);
  localparam int SET_W  = (SETS > 1) ? IDX_B : 1;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int TAG_W  = BLK_W - IDX_B;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int RANK_W = WAY_W;

  logic [WAYS-1:0][TAG_W-1:0]  tag_mem  [SETS];
  logic [WAYS-1:0]             vld_mem  [SETS];
  logic [WAYS-1:0][RANK_W-1:0] rank_mem [SETS];

  ctl_state_t       state_q;
  logic [BLK_W-1:0] pf_blk_q;
  logic [BLK_W-1:0] req_blk, lk_blk;
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;

  logic                        lk_hit;
  logic [WAY_W-1:0]            lk_hit_way, lk_victim, touch_way;
  logic [WAYS-1:0][RANK_W-1:0] upd_ranks;

  assign req_ready = (state_q == ST_IDLE);
  assign req_blk   = req_addr[ADDR_W-1:OFF_W];
  assign lk_blk    = (state_q == ST_PREF) ? pf_blk_q : req_blk;
  assign lk_tag    = lk_blk[BLK_W-1:IDX_B];

  if (SETS > 1) begin : g_idx
    assign lk_set = lk_blk[SET_W-1:0];
  end else begin : g_noidx
    assign lk_set = '0;
  end

  cache_way_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .RANK_W(RANK_W), .WAY_W(WAY_W)
  ) u_match (
    .set_tags   (tag_mem[lk_set]),
    .set_valid  (vld_mem[lk_set]),
    .set_ranks  (rank_mem[lk_set]),
    .look_tag   (lk_tag),
    .hit        (lk_hit),
    .hit_way    (lk_hit_way),
    .victim_way (lk_victim)
  );

  assign touch_way = lk_hit ? lk_hit_way : lk_victim;

  cache_rank_update #(
    .WAYS(WAYS), .RANK_W(RANK_W), .WAY_W(WAY_W)
  ) u_rank (
    .cur_ranks (rank_mem[lk_set]),
    .touch_way (touch_way),
    .new_ranks (upd_ranks)
  );

  // Tag array: written only on allocation, no reset needed.
  always_ff @(posedge clk) begin
    if (!rst && !lk_hit && (state_q == ST_PREF || req_valid))
      tag_mem[lk_set][lk_victim] <= lk_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      pf_blk_q   <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      cnt_mem_rd <= '0;
      cnt_mem_wr <= '0;
      cnt_hit    <= '0;
      cnt_miss   <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_mem[s] <= '0;
        for (int w = 0; w < WAYS; w++) rank_mem[s][w] <= RANK_W'(w);
      end
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            rsp_valid        <= 1'b1;
            rsp_hit          <= lk_hit;
            rank_mem[lk_set] <= upd_ranks;
            if (req_write) cnt_mem_wr <= cnt_mem_wr + 1'b1;
            if (lk_hit) begin
              cnt_hit <= cnt_hit + 1'b1;
            end else begin
              cnt_miss                   <= cnt_miss + 1'b1;
              cnt_mem_rd                 <= cnt_mem_rd + 1'b1;
              vld_mem[lk_set][lk_victim] <= 1'b1;
              if (pf_en) begin
                pf_blk_q <= req_blk + 1'b1;
                state_q  <= ST_PREF;
              end
            end
          end
        end
        ST_PREF: begin
          if (!lk_hit) begin
            cnt_mem_rd                 <= cnt_mem_rd + 1'b1;
            vld_mem[lk_set][lk_victim] <= 1'b1;
            rank_mem[lk_set]           <= upd_ranks;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             pf_en,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] cnt_mem_rd,
  input logic [CNT_W-1:0] cnt_mem_wr,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_miss
);
  // R3: a response follows only an accepted access
  assert_rsp_follows_accept_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready));

  // R3: a reported hit bumps the hit counter
  assert_hit_counted_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (cnt_hit == $past(cnt_hit) + 1'b1));

  // R4: a reported miss bumps miss and read counters
  assert_miss_counted_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (cnt_miss == $past(cnt_miss) + 1'b1 &&
                                 cnt_mem_rd == $past(cnt_mem_rd) + 1'b1));

  // R6: each accepted write adds exactly one memory write
  assert_write_through_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_write)) |-> (cnt_mem_wr == $past(cnt_mem_wr) + 1'b1));

  // R8: hit/miss counters never move without a response
  assert_pf_no_hitmiss_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> ($stable(cnt_hit) && $stable(cnt_miss)));

  // R10: a miss with prefetch on stalls the request side
  assert_pf_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit && pf_en) |-> !req_ready);

  // R10: the stall lasts a single cycle
  assert_stall_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> req_ready);

  // R11: with prefetch off the controller never stalls
  assert_no_pf_no_stall_R11: assert property (@(posedge clk) disable iff (rst)
    !pf_en |-> req_ready);
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pf_en      (pf_en),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .cnt_mem_rd (cnt_mem_rd),
  .cnt_mem_wr (cnt_mem_wr),
  .cnt_hit    (cnt_hit),
  .cnt_miss   (cnt_miss)
);

// File: tb/tb_cache_tag_ctrl.sv
module tb_cache_tag_ctrl;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pf_en = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [47:0]      req_addr = '0;
  logic             req_write = 1'b0;
  logic             rsp_valid, rsp_hit;
  logic [CNT_W-1:0] cnt_mem_rd, cnt_mem_wr, cnt_hit, cnt_miss;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  cache_tag_ctrl #(.SETS(2), .WAYS(2), .BLOCK_BYTES(4), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .pf_en(pf_en),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .cnt_mem_rd(cnt_mem_rd), .cnt_mem_wr(cnt_mem_wr),
    .cnt_hit(cnt_hit), .cnt_miss(cnt_miss)
  );

  // {write, address, expected hit}; 2 sets, 2 ways, 4-byte blocks, prefetch off.
  // set = addr[2], tag = addr[47:3]. Checks R2, R3, R4, R5, R6, R11.
  localparam logic [49:0] VEC [11] = '{
    {1'b0, 48'h00, 1'b0},  // set0 tag0 miss
    {1'b0, 48'h08, 1'b0},  // set0 tag1 miss
    {1'b0, 48'h00, 1'b1},  // hit, tag1 now LRU
    {1'b1, 48'h10, 1'b0},  // write miss evicts tag1
    {1'b0, 48'h08, 1'b0},  // miss evicts tag0 (R5)
    {1'b0, 48'h10, 1'b1},  // hit tag2
    {1'b0, 48'h00, 1'b0},  // miss evicts tag1
    {1'b1, 48'h04, 1'b0},  // set1 write miss
    {1'b1, 48'h06, 1'b1},  // same block, other offset (R2)
    {1'b0, 48'h14, 1'b0},  // set1 tag2 miss
    {1'b0, 48'h12, 1'b1}   // tag2 set0 still present
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_access(input logic wr, input logic [47:0] a,
                           output logic hit, output logic rdy_after);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 rsp_valid after accept", 64'(rsp_valid), 64'd1);
    hit       = rsp_hit;
    rdy_after = req_ready;
    if (!rdy_after) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", 64'(req_ready), 64'd1);
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 cnt_mem_rd reset", 64'(cnt_mem_rd), 64'd0);
    check("R1 cnt_mem_wr reset", 64'(cnt_mem_wr), 64'd0);
    check("R1 cnt_hit reset", 64'(cnt_hit), 64'd0);
    check("R1 cnt_miss reset", 64'(cnt_miss), 64'd0);
  endtask

  task automatic run_tests();
    logic h, r;
    // Part A: table, prefetch disabled
    pf_en = 1'b0;
    do_reset();
    for (int i = 0; i < 11; i++) begin
      do_access(VEC[i][49], VEC[i][48:1], h, r);
      check($sformatf("R2/R3/R4/R5 hit vector %0d", i), 64'(h), 64'(VEC[i][0]));
      check($sformatf("R11 ready stays high vector %0d", i), 64'(r), 64'd1);
    end
    check("R3 total hits", 64'(cnt_hit), 64'd4);
    check("R4 total misses", 64'(cnt_miss), 64'd7);
    check("R11 reads only on demand misses", 64'(cnt_mem_rd), 64'd7);
    check("R6 writes count hit and miss", 64'(cnt_mem_wr), 64'd3);

    // Part B: directed prefetch scenario; block b = addr>>2, set = b&1
    pf_en = 1'b1;
    do_reset();
    check("R1 lines invalid after reset", 64'(cnt_mem_rd), 64'd0);

    do_access(1'b0, 48'h00, h, r);   // b0 miss, pf b1 absent
    check("R7 miss b0", 64'(h), 64'd0);
    check("R10 stall after pf miss", 64'(r), 64'd0);
    check("R8 reads after pf b1", 64'(cnt_mem_rd), 64'd2);

    do_access(1'b0, 48'h04, h, r);   // b1 hit (prefetched)
    check("R8 prefetched block hits", 64'(h), 64'd1);
    check("R7 no prefetch on hit", 64'(cnt_mem_rd), 64'd2);
    check("R10 no stall on hit", 64'(r), 64'd1);

    do_access(1'b0, 48'h08, h, r);   // b2 miss, pf b3 absent
    check("R8 reads after pf b3", 64'(cnt_mem_rd), 64'd4);

    do_access(1'b0, 48'h14, h, r);   // b5 miss evicts b1, pf b6 evicts b0
    check("R8 reads after pf b6", 64'(cnt_mem_rd), 64'd6);

    do_access(1'b0, 48'h04, h, r);   // b1 miss evicts b3, pf b2 present
    check("R9 b1 miss", 64'(h), 64'd0);
    check("R9 present prefetch costs no read", 64'(cnt_mem_rd), 64'd7);

    do_access(1'b0, 48'h20, h, r);   // b8 miss must evict b2 (LRU untouched), pf b9
    check("R9 reads after b8", 64'(cnt_mem_rd), 64'd9);

    do_access(1'b0, 48'h18, h, r);   // b6 survives
    check("R9 b6 kept by LRU order", 64'(h), 64'd1);

    do_access(1'b0, 48'h08, h, r);   // b2 was evicted
    check("R9 b2 evicted", 64'(h), 64'd0);
    check("R8 reads after pf b3 again", 64'(cnt_mem_rd), 64'd11);

    do_access(1'b1, 48'h0C, h, r);   // write hit on prefetched b3
    check("R6 write hit on prefetched block", 64'(h), 64'd1);
    check("R6 write counted", 64'(cnt_mem_wr), 64'd1);

    check("R8 prefetch not in hit count", 64'(cnt_hit), 64'd3);
    check("R8 prefetch not in miss count", 64'(cnt_miss), 64'd6);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule